// File: doc/BRIEF.md
# Partitioned SIMD Integer ALU

This unit executes one packed-integer operation per cycle on two 128-bit source words. The lane-size code splits each word into sixteen byte lanes, eight halfword lanes or four word lanes, and every lane is computed at the same time. The operations are wrapping add and subtract, signed and unsigned minimum and maximum, the three per-lane shifts, bitwise logic, and a per-lane count of leading zeros. A whole-word funnel extract is also provided: it joins both operands into 256 bits and picks out a 128-bit window.

An issue stage presents the operands with a valid strobe. The result comes back registered one cycle later with its own valid. The result register is loaded only on a valid issue and keeps its value in every other cycle. One shared byte-sliced adder serves add, subtract and the min/max comparisons. Its carry is cut at each lane boundary that the lane-size code chooses.

Top module: `simd_alu`

## Requirements
- R1: `in_size` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, 2 or 3 gives 32-bit lanes. Lane i takes bits [i*w+w-1 : i*w], and no lane's result depends on any other lane's bits.
- R2: Opcode 0 (add) and opcode 1 (subtract, A minus B) work per lane and wrap modulo 2^w.
- R3: Opcodes 2 (min) and 3 (max) compare lanes as signed two's-complement values. Opcodes 10 (min) and 11 (max) compare them as unsigned values.
- R4: Opcodes 4 (shift left logical), 5 (shift right logical) and 6 (shift right arithmetic) shift each lane of A by `shamt` modulo w.
- R5: Opcodes 8 (AND), 9 (OR), 12 (XOR) and 13 (NOR) act bitwise on A and B, whatever the lane size.
- R6: Opcode 7 returns, in each lane, the number of leading zeros of A's element, zero-extended into the lane. An all-zero lane returns w.
- R7: Opcode 14 returns bits [shamt+127 : shamt] of the 256-bit value {A, B}, with shamt from 0 to 127. A shamt of 0 returns B.
- R8: Opcode 15 returns an all-zero result.
- R9: `out_valid` equals `in_valid` one cycle earlier. `out_result` takes the new result only after a cycle with `in_valid` high, and holds its value otherwise.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_result` to zero at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe |
| in_op | input | 4 | Operation code |
| in_size | input | 2 | Lane-size code |
| src_a | input | 128 | First operand |
| src_b | input | 128 | Second operand |
| shamt | input | 7 | Shift or funnel amount |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_result | output | 128 | Registered result |

## Verification
Carry isolation and the lane-size change land in the same cycle. Each issue can change both the lane-size code and the operation, so one cycle's adder result is taken with the carry cuts of one packing while the previous cycle was taken with another. The bench issues operations back to back and steps the lane size and opcode through every combination. It uses operands such as 0x80 and 0x7F patterns and all ones, which produce carries and borrows at every byte boundary. Each result is compared one cycle later against an arithmetic per-lane model. Idle cycles are mixed in to show that the held result does not move.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MIN  = 4'd2,
    OP_MAX  = 4'd3,
    OP_SLL  = 4'd4,
    OP_SRL  = 4'd5,
    OP_SRA  = 4'd6,
    OP_LZC  = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_MINU = 4'd10,
    OP_MAXU = 4'd11,
    OP_XOR  = 4'd12,
    OP_NOR  = 4'd13,
    OP_FSH  = 4'd14,
    OP_RSV  = 4'd15
  } simd_op_e;

  typedef enum logic [1:0] {
    LS_B8  = 2'd0,
    LS_H16 = 2'd1,
    LS_W32 = 2'd2,
    LS_W32X = 2'd3
  } lane_sz_e;

endpackage

// File: rtl/simd_addsub.sv
module simd_addsub #(
  parameter int DATA_W = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          lane_sz,
  input  logic                sub,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output logic [DATA_W-1:0]   sum,
  output logic [DATA_W/8-1:0] lt_s,
  output logic [DATA_W/8-1:0] lt_u
);
  localparam int NB = DATA_W / 8;

  logic [NB-1:0] cout;
  logic [NB-1:0] lts_last;
  logic [NB-1:0] ltu_last;

  // Byte-sliced chain; the carry restarts at every lane's first byte.
  always_comb begin
    logic c;
    logic first;
    logic [8:0] s9;
    c = sub;
    sum = '0;
    for (int i = 0; i < NB; i++) begin
      case (lane_sz)
        2'd0:    first = 1'b1;
        2'd1:    first = (i % 2 == 0);
        default: first = (i % 4 == 0);
      endcase
      s9 = {1'b0, a[i*8 +: 8]} + {1'b0, b[i*8 +: 8] ^ {8{sub}}}
         + {8'd0, first ? sub : c};
      sum[i*8 +: 8] = s9[7:0];
      c = s9[8];
      cout[i] = s9[8];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_byte
      assign ltu_last[g] = ~cout[g];
      assign lts_last[g] = (a[g*8+7] ^ b[g*8+7]) ? a[g*8+7] : sum[g*8+7];

      p_byte_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (lane_sz == 2'd0) |-> (sum[g*8 +: 8] ==
          (sub ? 8'(a[g*8 +: 8] - b[g*8 +: 8]) : 8'(a[g*8 +: 8] + b[g*8 +: 8]))));
    end
  endgenerate

  // Spread each lane's comparison (taken at its top byte) over the lane.
  always_comb begin
    for (int i = 0; i < NB; i++) begin
      int e;
      case (lane_sz)
        2'd0:    e = i;
        2'd1:    e = i | 1;
        default: e = i | 3;
      endcase
      lt_s[i] = lts_last[e];
      lt_u[i] = ltu_last[e];
    end
  end

endmodule

// File: rtl/simd_shift_unit.sv
module simd_shift_unit #(
  parameter int DATA_W = 128,
  parameter int LANE_W = 8,
  localparam int SW    = $clog2(LANE_W),
  localparam int NL    = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a,
  input  logic [SW-1:0]     shamt,
  output logic [DATA_W-1:0] sll,
  output logic [DATA_W-1:0] srl,
  output logic [DATA_W-1:0] sra,
  output logic [DATA_W-1:0] lzc
);

  function automatic logic [SW:0] count_lz(input logic [LANE_W-1:0] x);
    logic [SW:0] n;
    n = (SW+1)'(LANE_W);
    for (int k = 0; k < LANE_W; k++)
      if (x[k]) n = (SW+1)'(LANE_W - 1 - k);
    return n;
  endfunction

  genvar l;
  generate
    for (l = 0; l < NL; l++) begin : g_lane
      logic [LANE_W-1:0] x;
      assign x = a[l*LANE_W +: LANE_W];
      assign sll[l*LANE_W +: LANE_W] = x << shamt;
      assign srl[l*LANE_W +: LANE_W] = x >> shamt;
      assign sra[l*LANE_W +: LANE_W] = $signed(x) >>> shamt;
      assign lzc[l*LANE_W +: LANE_W] = LANE_W'(count_lz(x));

      p_lzc_bound_r6: assert property (@(posedge clk) disable iff (rst)
        lzc[l*LANE_W +: LANE_W] <= LANE_W'(LANE_W));
      p_lzc_top_set_r6: assert property (@(posedge clk) disable iff (rst)
        x[LANE_W-1] |-> (lzc[l*LANE_W +: LANE_W] == '0));
      p_shift_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (shamt == '0) |-> (sll[l*LANE_W +: LANE_W] == x && srl[l*LANE_W +: LANE_W] == x));
    end
  endgenerate

endmodule

// File: rtl/simd_funnel.sv
module simd_funnel #(
  parameter int DATA_W = 128,
  localparam int AW    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [AW-1:0]     amt,
  output logic [DATA_W-1:0] y
);
  logic [2*DATA_W-1:0] cat;

  assign cat = {a, b};
  assign y   = DATA_W'(cat >> amt);

  p_funnel_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (amt == '0) |-> (y == b));
  p_funnel_edge_r7: assert property (@(posedge clk) disable iff (rst)
    (amt == AW'(DATA_W - 1)) |-> (y == {a[DATA_W-2:0], b[DATA_W-1]}));

endmodule

// File: rtl/simd_alu.sv
module simd_alu #(
  parameter int DATA_W = 128
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [3:0]                in_op,
  input  logic [1:0]                in_size,
  input  logic [DATA_W-1:0]         src_a,
  input  logic [DATA_W-1:0]         src_b,
  input  logic [$clog2(DATA_W)-1:0] shamt,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         out_result
);
  import simd_alu_pkg::*;

  localparam int NB    = DATA_W / 8;
  localparam int NSIZE = 3;

  simd_op_e          op;
  logic [DATA_W-1:0] sum_w, mm_w, fsh_w, nxt;
  logic [NB-1:0]     lt_s, lt_u;
  logic              do_sub;
  logic [1:0]        sel;
  logic [DATA_W-1:0] sll_v [NSIZE];
  logic [DATA_W-1:0] srl_v [NSIZE];
  logic [DATA_W-1:0] sra_v [NSIZE];
  logic [DATA_W-1:0] lzc_v [NSIZE];
  logic              valid_q;
  logic [DATA_W-1:0] res_q;

  assign op     = simd_op_e'(in_op);
  assign do_sub = (op != OP_ADD);
  assign sel    = (in_size == 2'd0) ? 2'd0 : (in_size == 2'd1) ? 2'd1 : 2'd2;

  simd_addsub #(.DATA_W(DATA_W)) u_addsub (
    .clk(clk), .rst(rst), .lane_sz(in_size), .sub(do_sub),
    .a(src_a), .b(src_b), .sum(sum_w), .lt_s(lt_s), .lt_u(lt_u)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NSIZE; gi++) begin : g_sh
      localparam int LW = 8 << gi;
      simd_shift_unit #(.DATA_W(DATA_W), .LANE_W(LW)) u_sh (
        .clk(clk), .rst(rst), .a(src_a), .shamt(shamt[$clog2(LW)-1:0]),
        .sll(sll_v[gi]), .srl(srl_v[gi]), .sra(sra_v[gi]), .lzc(lzc_v[gi])
      );
    end
    for (gi = 0; gi < NB; gi++) begin : g_mm
      logic pick_a;
      assign pick_a = (in_op[3] ? lt_u[gi] : lt_s[gi]) ^ in_op[0];
      assign mm_w[gi*8 +: 8] = pick_a ? src_a[gi*8 +: 8] : src_b[gi*8 +: 8];
    end
  endgenerate

  simd_funnel #(.DATA_W(DATA_W)) u_fsh (
    .clk(clk), .rst(rst), .a(src_a), .b(src_b), .amt(shamt), .y(fsh_w)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:                   nxt = sum_w;
      OP_MIN, OP_MAX, OP_MINU, OP_MAXU: nxt = mm_w;
      OP_SLL:                           nxt = sll_v[sel];
      OP_SRL:                           nxt = srl_v[sel];
      OP_SRA:                           nxt = sra_v[sel];
      OP_LZC:                           nxt = lzc_v[sel];
      OP_AND:                           nxt = src_a & src_b;
      OP_OR:                            nxt = src_a | src_b;
      OP_XOR:                           nxt = src_a ^ src_b;
      OP_NOR:                           nxt = ~(src_a | src_b);
      OP_FSH:                           nxt = fsh_w;
      default:                          nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) res_q <= nxt;
    end
  end

  assign out_valid  = valid_q;
  assign out_result = res_q;

  p_valid_rise_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));
  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd15) |=> (out_result == '0));
  p_xor_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd12) |=> (out_result == ($past(src_a) ^ $past(src_b))));
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0));

endmodule

// File: tb/tb_simd_alu.sv
module tb_simd_alu;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [3:0]   in_op;
  logic [1:0]   in_size;
  logic [127:0] src_a, src_b;
  logic [6:0]   shamt;
  logic         out_valid;
  logic [127:0] out_result;

  int n_checks = 0;
  int n_fails  = 0;

  logic         exp_v;
  logic [127:0] exp_r;
  string        exp_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_alu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_size(in_size),
    .src_a(src_a), .src_b(src_b), .shamt(shamt),
    .out_valid(out_valid), .out_result(out_result)
  );

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:                return "R2";
      4'd2, 4'd3, 4'd10, 4'd11:  return "R3";
      4'd4, 4'd5, 4'd6:          return "R4";
      4'd8, 4'd9, 4'd12, 4'd13:  return "R5";
      4'd7:                      return "R6";
      4'd14:                     return "R7";
      default:                   return "R8";
    endcase
  endfunction

  function automatic logic [127:0] model(input logic [3:0] op, input logic [1:0] sz,
                                         input logic [127:0] a, input logic [127:0] b,
                                         input logic [6:0] amt);
    logic [255:0] cat;
    logic [127:0] res, t;
    int w, n, sh;
    longint unsigned mask, x, y, r;
    longint sx, sy;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    n = 128 / w;
    mask = (64'd1 << w) - 64'd1;
    sh = int'(amt) % w;
    if (op == 4'd14) begin
      cat = {a, b};
      cat = cat >> amt;
      return cat[127:0];
    end
    res = '0;
    for (int l = 0; l < n; l++) begin
      t = a >> (l * w);
      x = 64'(t[31:0]) & mask;
      t = b >> (l * w);
      y = 64'(t[31:0]) & mask;
      sx = (x >= (64'd1 << (w - 1))) ? longint'(x) - longint'(64'd1 << w) : longint'(x);
      sy = (y >= (64'd1 << (w - 1))) ? longint'(y) - longint'(64'd1 << w) : longint'(y);
      case (op)
        4'd0:  r = x + y;
        4'd1:  r = x - y;
        4'd2:  r = (sx < sy) ? x : y;
        4'd3:  r = (sx > sy) ? x : y;
        4'd10: r = (x < y) ? x : y;
        4'd11: r = (x > y) ? x : y;
        4'd4:  r = x << sh;
        4'd5:  r = x >> sh;
        4'd6:  r = longint'(sx >>> sh);
        4'd7: begin
          r = longint'(w);
          for (int k = 0; k < w; k++) if (x[k]) r = longint'(w - 1 - k);
        end
        4'd8:  r = x & y;
        4'd9:  r = x | y;
        4'd12: r = x ^ y;
        4'd13: r = ~(x | y);
        default: r = 0;
      endcase
      r = r & mask;
      t = 128'(r);
      res = res | (t << (l * w));
    end
    return res;
  endfunction

  function automatic logic [127:0] corner(input int k);
    case (k % 8)
      0: return '0;
      1: return '1;
      2: return {16{8'h80}};
      3: return {16{8'h7f}};
      4: return {8{16'h8000}};
      5: return {4{32'h7fffffff}};
      6: return {16{8'h01}};
      default: return 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    endcase
  endfunction

  task automatic check_out();
    n_checks++;
    if (out_valid !== exp_v || out_result !== exp_r) begin
      n_fails++;
      $display("FAIL %s (R1 size %0d): valid %b result %h, expected valid %b result %h",
               exp_tag, in_size, out_valid, out_result, exp_v, exp_r);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] op, input logic [1:0] sz,
                      input logic [127:0] a, input logic [127:0] b, input logic [6:0] amt);
    @(negedge clk);
    check_out();
    in_valid = v; in_op = op; in_size = sz; src_a = a; src_b = b; shamt = amt;
    exp_v = v;
    if (v) begin
      exp_r = model(op, sz, a, b, amt);
      exp_tag = tag_of(op);
    end else begin
      exp_tag = "R9";
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int amts[4] = '{0, 1, 9, 127};
    rst = 1'b1; in_valid = 1'b1; in_op = 4'd0; in_size = 2'd0;
    src_a = '1; src_b = '1; shamt = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    exp_v = 1'b0; exp_r = '0; exp_tag = "R10";
    check_out();
    rst = 1'b0; in_valid = 1'b0;

    // Sweep every opcode and lane size over the corner operands, back to back.
    for (int op = 0; op < 16; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int ai = 0; ai < 8; ai++)
          for (int bi = 0; bi < 8; bi++)
            step(1'b1, 4'(op), 2'(sz), corner(ai), corner(bi), 7'(amts[(ai + bi) % 4]));

    // R4 and R7: every shift amount.
    for (int opi = 0; opi < 4; opi++)
      for (int sz = 0; sz < 3; sz++)
        for (int amt = 0; amt < 128; amt++) begin
          logic [3:0] o;
          o = (opi == 3) ? 4'd14 : 4'(4 + opi);
          step(1'b1, o, 2'(sz), corner(amt + 1), corner(amt + 4), 7'(amt));
        end

    // R9: random traffic with idle cycles holding the result.
    for (int i = 0; i < 3000; i++) begin
      logic v;
      v = ($urandom % 4) != 0;
      step(v, 4'($urandom), 2'($urandom), rnd128(), rnd128(), 7'($urandom));
    end

    // R10: reset in the middle of traffic.
    step(1'b1, 4'd9, 2'd0, '1, '0, 7'd0);
    @(negedge clk);
    check_out();
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    exp_v = 1'b0; exp_r = '0; exp_tag = "R10";
    check_out();
    rst = 1'b0; in_valid = 1'b0;
    step(1'b0, 4'd0, 2'd0, '0, '0, 7'd0);
    step(1'b0, 4'd0, 2'd0, '0, '0, 7'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule